// File: doc/BRIEF.md
# Sub-word Load/Store Lane Aligner

This block sits between a processor's load/store path and a data memory that is addressed by byte but read and written one 32-bit word at a time. Each request carries a byte address, an access size (byte, halfword or word), a zero-fill flag and a store/load selector. If the request is naturally aligned, the block issues one word-aligned memory read or write. A write carries byte-lane strobes and store data copied into every lane. When read data returns, the block picks out the addressed byte or halfword and widens it to 32 bits, either by sign extension or by zero fill.

A request that breaks natural alignment, or that uses the reserved size code, raises a fault pulse. No memory strobe is issued for it. Lanes are big-endian: byte offset 0 within a word occupies bits 31:24. The memory port assumes a synchronous read: data for a read strobe seen at one clock edge is valid after the following edge.

Top module: `mem_lane_align`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `mem_rd_en`, `mem_wr_en`, `fault`, `ld_valid`, `mem_be` and `ld_data` are all zero.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. A byte access is legal at any address, a halfword needs address bit 0 clear, a word needs address bits 1:0 both clear, and size 11 is never legal. An illegal request raises `fault` for exactly the one cycle after the request. That cycle carries no read or write strobe, and memory contents are left unchanged.
- R3: A legal request produces, in the cycle after it, exactly one of `mem_rd_en` (load) or `mem_wr_en` (store), with `mem_addr` equal to the request address with bits 1:0 cleared.
- R4: `mem_be` bit 3 covers data bits 31:24 and bit 0 covers bits 7:0. A byte access at offset k sets only bit 3-k. A halfword at offset 0 gives 1100 and at offset 2 gives 0011. A word gives 1111.
- R5: Store data is copied across lanes: a byte store drives `{4{wdata[7:0]}}`, a halfword `{2{wdata[15:0]}}`, and a word the data unchanged.
- R6: A load takes the byte at offset k from bits 31-8k down to 24-8k of the returned word, and the halfword at offset 0 or 2 from the matching upper or lower 16 bits.
- R7: A byte load with the zero-fill flag clear copies bit 7 into bits 31:8 (0xFF gives 0xFFFFFFFF, 0x11 gives 0x00000011). With the flag set, bits 31:8 are zero (0xFF gives 0x000000FF).
- R8: A halfword load copies bit 15 into bits 31:16 when the zero-fill flag is clear and zeroes them when it is set.
- R9: A word load returns the memory word unchanged, whatever the zero-fill flag.
- R10: `ld_valid` pulses for one cycle, three cycles after a legal load request (one cycle after the memory read data is valid), with `ld_data` valid in that cycle.
- R11: Stores and illegal requests never produce `ld_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_unsigned | input | 1 | Zero-fill flag for loads |
| req_addr | input | ADDR_W (32) | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane write enables |
| mem_addr | output | ADDR_W (32) | Word-aligned byte address |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read data, valid one cycle after the read strobe |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Aligned and extended load result |
| fault | output | 1 | Misaligned or reserved-size request |

## Verification
A wrong legality decision shows up in the cycle after the request. It appears either as a fault pulse beside a strobe, or as a strobe where a fault was due. A misaligned store that gets through corrupts memory, and that damage surfaces at the next load of the word. A corrupted lane mask or a wrong replication pattern changes which bytes land in memory, so later word and sub-word loads return values that differ from the arithmetic reference. A stale offset or size held for the return path corrupts `ld_data` three cycles after the request. The sweep covers every offset, size and fill mode.

// File: rtl/lau_pkg.sv
package lau_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = 2 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        acc_size_e          size;
        logic               zero_fill;
        logic [OFS_W-1:0]   ofs;
    } ld_ctl_t;

    // natural alignment rule per size
    function automatic logic size_legal(acc_size_e sz, logic [OFS_W-1:0] ofs);
        case (sz)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return (ofs[0] == 1'b0);
            SZ_WORD: return (ofs == '0);
            default: return 1'b0;
        endcase
    endfunction

    // big-endian lane strobes: offset 0 is the top lane
    function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFS_W-1:0] ofs);
        logic [LANES-1:0] base;
        case (sz)
            SZ_BYTE: base = {1'b1, {(LANES-1){1'b0}}};
            SZ_HALF: base = {2'b11, {(LANES-2){1'b0}}};
            SZ_WORD: base = '1;
            default: base = '0;
        endcase
        return base >> ofs;
    endfunction

    function automatic logic [WORD_W-1:0] spread_wdata(acc_size_e sz, logic [WORD_W-1:0] wd);
        case (sz)
            SZ_BYTE: return {LANES{wd[LANE_W-1:0]}};
            SZ_HALF: return {(LANES/2){wd[HALF_W-1:0]}};
            default: return wd;
        endcase
    endfunction

    // move the addressed item to the top, then widen it
    function automatic logic [WORD_W-1:0] shape_load(ld_ctl_t c, logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] sh;
        logic              fill;
        sh = w << (int'(c.ofs) * LANE_W);
        case (c.size)
            SZ_BYTE: begin
                fill = ~c.zero_fill & sh[WORD_W-1];
                return {{(WORD_W-LANE_W){fill}}, sh[WORD_W-1 -: LANE_W]};
            end
            SZ_HALF: begin
                fill = ~c.zero_fill & sh[WORD_W-1];
                return {{(WORD_W-HALF_W){fill}}, sh[WORD_W-1 -: HALF_W]};
            end
            default: return w;
        endcase
    endfunction

endpackage

// File: rtl/lau_req_stage.sv
module lau_req_stage
    import lau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic               req_unsigned,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [LANES-1:0]   mem_be,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               fault,
    output ld_ctl_t            ld_ctl
);

    logic [OFS_W-1:0] ofs;
    acc_size_e        sz;
    logic             legal;

    assign ofs   = req_addr[OFS_W-1:0];
    assign sz    = acc_size_e'(req_size);
    assign legal = size_legal(sz, ofs);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            fault     <= 1'b0;
            mem_be    <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            ld_ctl    <= '0;
        end else begin
            mem_rd_en <= req_valid & legal & ~req_store;
            mem_wr_en <= req_valid & legal & req_store;
            fault     <= req_valid & ~legal;
            if (req_valid) begin
                mem_be    <= legal ? lane_mask(sz, ofs) : '0;
                mem_addr  <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                mem_wdata <= spread_wdata(sz, req_wdata);
                ld_ctl    <= '{size: sz, zero_fill: req_unsigned, ofs: ofs};
            end
        end
    end

endmodule

// File: rtl/lau_load_shaper.sv
module lau_load_shaper
    import lau_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_issued,
    input  ld_ctl_t            issue_ctl,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               ld_valid,
    output logic [WORD_W-1:0]  ld_data
);

    logic    wait_vld;
    ld_ctl_t wait_ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_vld <= 1'b0;
            wait_ctl <= '0;
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            wait_vld <= rd_issued;
            wait_ctl <= issue_ctl;
            ld_valid <= wait_vld;
            if (wait_vld) begin
                ld_data <= shape_load(wait_ctl, mem_rdata);
            end
        end
    end

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
    import lau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_store,
    input  logic [1:0]         req_size,
    input  logic               req_unsigned,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [LANES-1:0]   mem_be,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               ld_valid,
    output logic [WORD_W-1:0]  ld_data,
    output logic               fault
);

    ld_ctl_t issue_ctl;

    lau_req_stage #(.ADDR_W(ADDR_W)) i_req (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_store    (req_store),
        .req_size     (req_size),
        .req_unsigned (req_unsigned),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .mem_rd_en    (mem_rd_en),
        .mem_wr_en    (mem_wr_en),
        .mem_be       (mem_be),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .fault        (fault),
        .ld_ctl       (issue_ctl)
    );

    lau_load_shaper i_shape (
        .clk       (clk),
        .rst       (rst),
        .rd_issued (mem_rd_en),
        .issue_ctl (issue_ctl),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_data   (ld_data)
    );

endmodule

// File: rtl/lau_checker.sv
module lau_checker
    import lau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               mem_rd_en,
    input logic               mem_wr_en,
    input logic [LANES-1:0]   mem_be,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               ld_valid,
    input logic               fault
);

    p_fault_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        fault |-> !(mem_rd_en || mem_wr_en));

    p_fault_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past(req_valid));

    p_word_misalign_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> fault);

    p_strobe_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> $past(req_valid));

    p_rd_wr_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00));

    p_be_shape_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_be inside {4'b1000, 4'b0100, 4'b0010, 4'b0001,
                                      4'b1100, 4'b0011, 4'b1111}));

    p_ld_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_rd_en, 2));

endmodule

bind mem_lane_align lau_checker #(.ADDR_W(ADDR_W)) i_lau_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .ld_valid  (ld_valid),
    .fault     (fault)
);

// File: tb/test_mem_lane_align.sv
module test_mem_lane_align;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_rd_en, mem_wr_en, ld_valid, fault;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] bmem [16];
    logic [7:0]  ref_b [64];

    always #2 clk = ~clk;

    mem_lane_align i_mem_lane_align (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .fault(fault)
    );

    // synchronous word memory model, bit 3 of the strobe = bits 31:24
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) bmem[i] <= '0;
            mem_rdata <= '0;
        end else begin
            if (mem_wr_en)
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) bmem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            if (mem_rd_en) mem_rdata <= bmem[mem_addr[5:2]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic access(input logic st, input logic [1:0] sz, input logic u,
                          input logic [31:0] a, input logic [31:0] wd);
        logic        legal;
        logic [3:0]  be;
        logic [31:0] rep, exp_ld;
        logic [7:0]  b;
        logic [15:0] h;
        int          base;
        string       ltag;
        base = int'(a[5:0]);
        case (sz)
            2'd0: begin legal = 1'b1;            be = 4'b1000 >> a[1:0]; rep = {4{wd[7:0]}}; end
            2'd1: begin legal = (a[0] == 1'b0);  be = 4'b1100 >> a[1:0]; rep = {2{wd[15:0]}}; end
            2'd2: begin legal = (a[1:0] == 2'b0); be = 4'b1111;          rep = wd; end
            default: begin legal = 1'b0;         be = 4'b0000;           rep = wd; end
        endcase
        exp_ld = '0;
        ltag = "R9";
        if (!st && legal) begin
            b = ref_b[base];
            h = {ref_b[base], ref_b[(base + 1) % 64]};
            case (sz)
                2'd0: begin exp_ld = u ? {24'h0, b} : {{24{b[7]}}, b}; ltag = "R7/R6"; end
                2'd1: begin exp_ld = u ? {16'h0, h} : {{16{h[15]}}, h}; ltag = "R8/R6"; end
                default: exp_ld = {ref_b[base], ref_b[base+1], ref_b[base+2], ref_b[base+3]};
            endcase
        end
        if (st && legal) begin
            case (sz)
                2'd0: ref_b[base] = wd[7:0];
                2'd1: begin ref_b[base] = wd[15:8]; ref_b[base+1] = wd[7:0]; end
                default: begin
                    ref_b[base] = wd[31:24]; ref_b[base+1] = wd[23:16];
                    ref_b[base+2] = wd[15:8]; ref_b[base+3] = wd[7:0];
                end
            endcase
        end
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = u;
        req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 fault", {31'b0, fault}, {31'b0, ~legal});
        chk("R3 rd strobe", {31'b0, mem_rd_en}, {31'b0, legal & ~st});
        chk("R3 wr strobe", {31'b0, mem_wr_en}, {31'b0, legal & st});
        if (legal) begin
            chk("R3 addr", mem_addr, {a[31:2], 2'b00});
            if (st) begin
                chk("R4 byte enables", {28'b0, mem_be}, {28'b0, be});
                chk("R5 store data", mem_wdata, rep);
            end
        end
        @(negedge clk);
        chk("R2 fault one cycle", {31'b0, fault}, 32'd0);
        chk("R10 early valid", {31'b0, ld_valid}, 32'd0);
        @(negedge clk);
        if (!st && legal) begin
            chk("R10 ld_valid", {31'b0, ld_valid}, 32'd1);
            chk(ltag, ld_data, exp_ld);
        end else begin
            chk("R11 no ld_valid", {31'b0, ld_valid}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_b[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk("R1 rd", {31'b0, mem_rd_en}, 32'd0);
        chk("R1 wr", {31'b0, mem_wr_en}, 32'd0);
        chk("R1 fault", {31'b0, fault}, 32'd0);
        chk("R1 ld_valid", {31'b0, ld_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 be", {28'b0, mem_be}, 32'd0);
        chk("R1 ld_data", ld_data, 32'd0);

        access(1'b1, 2'd2, 1'b0, 32'd0,  32'h11FF807F);
        access(1'b1, 2'd2, 1'b0, 32'd4,  32'h80017FFE);
        access(1'b1, 2'd2, 1'b0, 32'd8,  32'hFFFF0000);
        access(1'b1, 2'd2, 1'b0, 32'd12, 32'h0123ABCD);

        // every offset, size and fill mode on the first four words
        for (int a = 0; a < 16; a++)
            for (int s = 0; s < 4; s++)
                for (int u = 0; u < 2; u++)
                    access(1'b0, 2'(s), 1'(u), 32'(a), 32'h0);

        // stores of all sizes at every offset, then read back
        for (int a = 16; a < 32; a++)
            for (int s = 0; s < 4; s++)
                access(1'b1, 2'(s), 1'b0, 32'(a), 32'hC35A9600 ^ (32'(a) * 32'h01030507) ^ 32'(s));
        for (int a = 16; a < 32; a++)
            for (int s = 0; s < 3; s++)
                for (int u = 0; u < 2; u++)
                    access(1'b0, 2'(s), 1'(u), 32'(a), 32'h0);

        // illegal stores into a known word must leave it untouched
        access(1'b1, 2'd2, 1'b0, 32'd34, 32'hDEADBEEF);
        access(1'b1, 2'd1, 1'b0, 32'd33, 32'hDEADBEEF);
        access(1'b1, 2'd3, 1'b0, 32'd32, 32'hDEADBEEF);
        access(1'b0, 2'd2, 1'b0, 32'd32, 32'h0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule